// File: doc/BRIEF.md
# Ethernet Statistics Counter Bank

This block keeps the frame statistics of an Ethernet MAC. A transmit side and a receive side each report one outcome summary per frame, as a single-cycle `valid` strobe. The summary carries the collision count and the error flags of the frame, and on the receive side also its length. Two classifiers sort each summary into one or more of fifteen saturating counters. The sorting follows fixed precedence, exclusion and double-count rules, so the counters are not independent event counters.

The strobes have no `ready` signal. The bank takes a summary on every cycle in which `valid` is high and never applies back-pressure, so the MAC does not need to hold a summary back. One summary from each side can arrive in the same cycle, because the two sides update disjoint sets of counters. Software reads a counter through a plain read port. `rd_data` shows the counter selected by `rd_addr` in the same cycle. A cycle with `rd_en` high clears that counter at the next clock edge.

Top module: `eth_stats_bank`

## Requirements
- R1: After reset, every counter reads zero, and any address of 15 or above reads zero.
- R2: A transmit summary with fewer than 16 collisions and no underrun adds one to the sent-frame counter (address 0, 24 bits).
- R3: If there is no carrier loss and no underrun, exactly 1 collision adds one to the one-collision counter (address 1, 16 bits). A count of 2 to 15 adds one to the multi-collision counter (address 2, 16 bits).
- R4: A collision count of 16 or more, with no underrun, adds one to the abandoned-frame counter (address 9, 8 bits) and not to the sent-frame counter.
- R5: A late collision flag with no carrier loss and no underrun adds one to the late-collision counter (address 8, 8 bits). This is in addition to the collision counter chosen by the collision count.
- R6: A transmit underrun adds one only to the underrun counter (address 10, 8 bits). No other transmit counter moves for that frame.
- R7: A frame with zero collisions whose first attempt was deferred, with no carrier loss and no underrun, adds one to the deferred counter (address 3, 16 bits).
- R8: An address-matched receive frame of 64 to 1518 bytes with no CRC error and no code error is good. A good frame adds one to the received-frame counter (address 4, 24 bits). If no buffer was free, it adds one to the dropped-frame counter (address 5, 16 bits) instead.
- R9: A matched frame of 64 to 1518 bytes with a CRC error goes to one of two counters. A whole number of bytes sends it to the CRC-error counter (address 6, 8 bits). The trailing-bits flag sends it to the alignment counter (address 7, 8 bits).
- R10: A matched frame over 1518 bytes goes to the jabber counter (address 13) if it has a CRC error, and to the oversize counter (address 12) if it does not. A matched frame under 64 bytes without a CRC error goes to the undersize counter (address 14). All three counters are 8 bits.
- R11: A matched frame with a code error adds one only to the code-error counter (address 11, 8 bits). A frame without an address match changes no counter.
- R12: Each counter stops at its all-ones value and does not wrap.
- R13: A read clears the addressed counter at the following edge. If an increment for that counter arrives in the same cycle as the read, the counter holds 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit summary strobe |
| tx_coll | input | COLL_W | Collisions seen by the frame |
| tx_late | input | 1 | A collision came after the slot time |
| tx_underrun | input | 1 | Transmit data underrun |
| tx_carrier_lost | input | 1 | Carrier lost during transmission |
| tx_deferred | input | 1 | First attempt deferred by carrier sense |
| rx_valid | input | 1 | Receive summary strobe |
| rx_len | input | LEN_W | Frame length in bytes |
| rx_addr_match | input | 1 | Destination address recognised |
| rx_code_err | input | 1 | Symbol error signalled during reception |
| rx_crc_err | input | 1 | Frame check failed |
| rx_dribble | input | 1 | Frame ends with a partial byte |
| rx_no_buf | input | 1 | No receive buffer was free |
| rd_en | input | 1 | Read strobe; clears the addressed counter |
| rd_addr | input | ADDR_W | Counter select |
| rd_data | output | DATA_W | Selected counter, zero-extended |

## Verification
The two things that can land on one counter in the same cycle are a clearing read and a classified increment. The bench makes this happen in a directed case: it holds `rd_en` on the sent-frame counter while a good transmit summary is present. It then does the same many times in a mixed phase, where reads hit counters that are being incremented at random. A behavioural model in the bench applies the rule that the read wins and the increment survives as a value of 1. The bench compares `rd_data` against this model on every cycle. Saturation and these collisions are judged by the same comparison.

// File: rtl/eth_stats_pkg.sv
package eth_stats_pkg;
  localparam int NCNT = 15;

  typedef enum logic [3:0] {
    C_TX_OK    = 4'd0,
    C_SCOL     = 4'd1,
    C_MCOL     = 4'd2,
    C_DEFER    = 4'd3,
    C_RX_OK    = 4'd4,
    C_DISCARD  = 4'd5,
    C_FCS      = 4'd6,
    C_ALIGN    = 4'd7,
    C_LCOL     = 4'd8,
    C_XCOL     = 4'd9,
    C_UNDERRUN = 4'd10,
    C_CODE     = 4'd11,
    C_LONG     = 4'd12,
    C_JABBER   = 4'd13,
    C_SHORT    = 4'd14
  } cnt_id_e;

  function automatic int cnt_width(int idx, int wide_w, int mid_w, int narrow_w);
    if (idx == 0 || idx == 4) return wide_w;
    if (idx == 1 || idx == 2 || idx == 3 || idx == 5) return mid_w;
    return narrow_w;
  endfunction
endpackage

// File: rtl/eth_stats_tx_class.sv
module eth_stats_tx_class
  import eth_stats_pkg::*;
#(
  parameter int COLL_W   = 5,
  parameter int MAX_COLL = 16
) (
  input  logic              valid,
  input  logic [COLL_W-1:0] coll,
  input  logic              late,
  input  logic              underrun,
  input  logic              carrier_lost,
  input  logic              deferred,
  output logic [NCNT-1:0]   inc
);
  localparam logic [COLL_W-1:0] LIMIT = COLL_W'(MAX_COLL);
  localparam logic [COLL_W-1:0] ONE   = COLL_W'(1);
  localparam logic [COLL_W-1:0] ZERO  = '0;

  logic abandoned;
  assign abandoned = (coll >= LIMIT);

  always_comb begin
    inc = '0;
    if (valid) begin
      if (underrun) begin
        inc[C_UNDERRUN] = 1'b1;
      end else begin
        if (abandoned) inc[C_XCOL]  = 1'b1;
        else           inc[C_TX_OK] = 1'b1;
        if (!carrier_lost) begin
          if (!abandoned && coll == ONE)               inc[C_SCOL]  = 1'b1;
          if (!abandoned && coll > ONE)                inc[C_MCOL]  = 1'b1;
          if (coll == ZERO && deferred)                inc[C_DEFER] = 1'b1;
          if (late)                                    inc[C_LCOL]  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eth_stats_rx_class.sv
module eth_stats_rx_class
  import eth_stats_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic             valid,
  input  logic [LEN_W-1:0] len,
  input  logic             addr_match,
  input  logic             code_err,
  input  logic             crc_err,
  input  logic             dribble,
  input  logic             no_buf,
  output logic [NCNT-1:0]  inc
);
  localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_LEN);

  always_comb begin
    inc = '0;
    if (valid && addr_match) begin
      if (code_err) begin
        inc[C_CODE] = 1'b1;
      end else if (len > HI) begin
        if (crc_err) inc[C_JABBER] = 1'b1;
        else         inc[C_LONG]   = 1'b1;
      end else if (len < LO) begin
        if (!crc_err) inc[C_SHORT] = 1'b1;
      end else if (crc_err) begin
        if (dribble) inc[C_ALIGN] = 1'b1;
        else         inc[C_FCS]   = 1'b1;
      end else if (no_buf) begin
        inc[C_DISCARD] = 1'b1;
      end else begin
        inc[C_RX_OK] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/eth_stats_cnt.sv
module eth_stats_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)             q <= '0;
    else if (clr)           q <= inc ? W'(1) : '0;
    else if (inc && q != TOP) q <= q + W'(1);
  end
endmodule

// File: rtl/eth_stats_bank.sv
module eth_stats_bank
  import eth_stats_pkg::*;
#(
  parameter int WIDE_W   = 24,
  parameter int MID_W    = 16,
  parameter int NARROW_W = 8,
  parameter int LEN_W    = 14,
  parameter int COLL_W   = 5,
  parameter int MAX_COLL = 16,
  parameter int MIN_LEN  = 64,
  parameter int MAX_LEN  = 1518,
  localparam int DATA_W  = WIDE_W,
  localparam int ADDR_W  = $clog2(NCNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [COLL_W-1:0] tx_coll,
  input  logic              tx_late,
  input  logic              tx_underrun,
  input  logic              tx_carrier_lost,
  input  logic              tx_deferred,
  input  logic              rx_valid,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_addr_match,
  input  logic              rx_code_err,
  input  logic              rx_crc_err,
  input  logic              rx_dribble,
  input  logic              rx_no_buf,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [NCNT-1:0]   tx_inc, rx_inc, clr_vec;
  logic [DATA_W-1:0] cnt_ext [NCNT];

  eth_stats_tx_class #(.COLL_W(COLL_W), .MAX_COLL(MAX_COLL)) u_tx (
    .valid(tx_valid), .coll(tx_coll), .late(tx_late), .underrun(tx_underrun),
    .carrier_lost(tx_carrier_lost), .deferred(tx_deferred), .inc(tx_inc)
  );

  eth_stats_rx_class #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_rx (
    .valid(rx_valid), .len(rx_len), .addr_match(rx_addr_match),
    .code_err(rx_code_err), .crc_err(rx_crc_err), .dribble(rx_dribble),
    .no_buf(rx_no_buf), .inc(rx_inc)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    localparam int W = cnt_width(i, WIDE_W, MID_W, NARROW_W);
    logic [W-1:0] q;
    assign clr_vec[i] = rd_en && (rd_addr == ADDR_W'(i));
    eth_stats_cnt #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(tx_inc[i] | rx_inc[i]),
      .clr(clr_vec[i]), .q(q)
    );
    assign cnt_ext[i] = DATA_W'(q);
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCNT; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = cnt_ext[i];
  end
endmodule

// File: rtl/eth_stats_chk.sv
module eth_stats_chk
  import eth_stats_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int COLL_W = 5,
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic [COLL_W-1:0] tx_coll,
  input logic              tx_late,
  input logic              tx_underrun,
  input logic              tx_carrier_lost,
  input logic              rx_valid,
  input logic              rx_addr_match,
  input logic              rx_code_err,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [NCNT-1:0]   tx_inc,
  input logic [NCNT-1:0]   rx_inc
);
  localparam logic [NCNT-1:0] UND_ONLY  = NCNT'(1) << C_UNDERRUN;
  localparam logic [NCNT-1:0] CODE_ONLY = NCNT'(1) << C_CODE;

  logic [NCNT-1:0] inc_all;
  logic            addr_inc;
  assign inc_all  = tx_inc | rx_inc;
  assign addr_inc = (rd_addr < ADDR_W'(NCNT)) ? inc_all[rd_addr[3:0]] : 1'b0;

  AST_UNDERRUN_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_underrun |-> tx_inc == UND_ONLY); // R6

  AST_CODE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_addr_match && rx_code_err |-> rx_inc == CODE_ONLY); // R11

  AST_UNMATCHED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_addr_match) |-> rx_inc == '0); // R11

  AST_RX_ONE_BUCKET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rx_inc) <= 1); // R8

  AST_LATE_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_late && !tx_underrun && !tx_carrier_lost && tx_coll == COLL_W'(1)
    |-> tx_inc[C_LCOL] && tx_inc[C_SCOL]); // R5

  AST_ABANDON_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_underrun && tx_coll >= COLL_W'(16) |-> tx_inc[C_XCOL] && !tx_inc[C_TX_OK]); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr < ADDR_W'(NCNT) && !addr_inc) ##1 (rd_addr == $past(rd_addr))
    |-> rd_data == '0); // R13
endmodule

bind eth_stats_bank eth_stats_chk #(.ADDR_W(ADDR_W), .COLL_W(COLL_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_coll(tx_coll), .tx_late(tx_late),
  .tx_underrun(tx_underrun), .tx_carrier_lost(tx_carrier_lost), .rx_valid(rx_valid),
  .rx_addr_match(rx_addr_match), .rx_code_err(rx_code_err), .rd_en(rd_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .tx_inc(tx_inc), .rx_inc(rx_inc)
);

// File: tb/test_eth_stats_bank.sv
`timescale 1ns/1ps
module test_eth_stats_bank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_valid = 0, tx_late = 0, tx_underrun = 0, tx_carrier_lost = 0, tx_deferred = 0;
  logic [4:0] tx_coll = '0;
  logic rx_valid = 0, rx_addr_match = 0, rx_code_err = 0, rx_crc_err = 0, rx_dribble = 0, rx_no_buf = 0;
  logic [13:0] rx_len = '0;
  logic rd_en = 0;
  logic [3:0] rd_addr = 4'd15;
  logic [23:0] rd_data;

  int model [15];
  int maxv  [15];
  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;

  eth_stats_bank i_eth_stats_bank (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_coll(tx_coll), .tx_late(tx_late),
    .tx_underrun(tx_underrun), .tx_carrier_lost(tx_carrier_lost), .tx_deferred(tx_deferred),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_addr_match(rx_addr_match),
    .rx_code_err(rx_code_err), .rx_crc_err(rx_crc_err), .rx_dribble(rx_dribble),
    .rx_no_buf(rx_no_buf), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic step(input string tag);
    bit inc [15];
    int exp_v;
    bit big;
    #1;
    exp_v = (rd_addr < 15) ? model[rd_addr] : 0;
    compared++;
    if (rd_data !== 24'(exp_v)) begin
      mismatched++;
      $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, rd_addr, rd_data, exp_v);
    end
    foreach (inc[i]) inc[i] = 0;
    if (tx_valid) begin
      if (tx_underrun) inc[10] = 1;
      else begin
        big = (tx_coll >= 16);
        if (big) inc[9] = 1; else inc[0] = 1;
        if (!tx_carrier_lost) begin
          if (!big && tx_coll == 1) inc[1] = 1;
          if (!big && tx_coll >= 2) inc[2] = 1;
          if (tx_coll == 0 && tx_deferred) inc[3] = 1;
          if (tx_late) inc[8] = 1;
        end
      end
    end
    if (rx_valid && rx_addr_match) begin
      if (rx_code_err) inc[11] = 1;
      else if (rx_len > 1518) inc[rx_crc_err ? 13 : 12] = 1;
      else if (rx_len < 64) begin if (!rx_crc_err) inc[14] = 1; end
      else if (rx_crc_err) inc[rx_dribble ? 7 : 6] = 1;
      else inc[rx_no_buf ? 5 : 4] = 1;
    end
    for (int i = 0; i < 15; i++) begin
      if (rd_en && rd_addr == 4'(i)) model[i] = inc[i] ? 1 : 0;
      else if (inc[i] && model[i] < maxv[i]) model[i]++;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic quiet();
    tx_valid = 0; tx_late = 0; tx_underrun = 0; tx_carrier_lost = 0; tx_deferred = 0; tx_coll = 0;
    rx_valid = 0; rx_addr_match = 0; rx_code_err = 0; rx_crc_err = 0; rx_dribble = 0; rx_no_buf = 0;
    rx_len = 0; rd_en = 0; rd_addr = 4'd15;
  endtask

  task automatic tx(input int c, input bit lt, input bit un, input bit cl, input bit df, input string tag);
    quiet(); tx_valid = 1; tx_coll = 5'(c); tx_late = lt; tx_underrun = un;
    tx_carrier_lost = cl; tx_deferred = df;
    step(tag); quiet();
  endtask

  task automatic rx(input int len, input bit m, input bit ce, input bit crc, input bit drb, input bit nb, input string tag);
    quiet(); rx_valid = 1; rx_len = 14'(len); rx_addr_match = m; rx_code_err = ce;
    rx_crc_err = crc; rx_dribble = drb; rx_no_buf = nb;
    step(tag); quiet();
  endtask

  task automatic rd(input int a, input string tag);
    quiet(); rd_en = 1; rd_addr = 4'(a); step(tag); quiet();
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) begin
      model[i] = 0;
      maxv[i] = (i == 0 || i == 4) ? 24'hFFFFFF : (i == 1 || i == 2 || i == 3 || i == 5) ? 16'hFFFF : 255;
    end
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values, including the unused address
    for (int a = 0; a < 16; a++) rd(a, "R1");
    // R2 sent frame
    tx(0, 0, 0, 0, 0, "R2"); rd(0, "R2");
    // R3 single and multiple collisions, carrier loss excluded
    tx(1, 0, 0, 0, 0, "R3"); tx(5, 0, 0, 0, 0, "R3"); tx(15, 0, 0, 0, 0, "R3");
    tx(1, 0, 0, 1, 0, "R3");
    rd(1, "R3"); rd(2, "R3"); rd(0, "R3");
    // R4 abandoned after 16 collisions
    tx(16, 0, 0, 0, 0, "R4"); rd(9, "R4"); rd(0, "R4");
    // R5 late collision counted twice
    tx(1, 1, 0, 0, 0, "R5"); tx(3, 1, 0, 0, 0, "R5");
    rd(8, "R5"); rd(1, "R5"); rd(2, "R5");
    // R6 underrun exclusive
    tx(3, 1, 1, 0, 1, "R6");
    rd(10, "R6"); rd(0, "R6"); rd(2, "R6"); rd(8, "R6");
    // R7 deferred
    tx(0, 0, 0, 0, 1, "R7"); tx(2, 0, 0, 0, 1, "R7"); rd(3, "R7");
    // R8 good frames and dropped frames
    rx(64, 1, 0, 0, 0, 0, "R8"); rx(1518, 1, 0, 0, 1, 0, "R8");
    rx(1518, 1, 0, 0, 0, 1, "R8");
    rd(4, "R8"); rd(5, "R8");
    // R9 CRC versus alignment
    rx(100, 1, 0, 1, 0, 0, "R9"); rx(100, 1, 0, 1, 1, 0, "R9");
    rd(6, "R9"); rd(7, "R9"); rd(4, "R9");
    // R10 oversize, jabber, undersize
    rx(1519, 1, 0, 0, 0, 0, "R10"); rx(2000, 1, 0, 1, 0, 0, "R10");
    rx(63, 1, 0, 0, 0, 0, "R10"); rx(30, 1, 0, 1, 0, 0, "R10");
    rd(12, "R10"); rd(13, "R10"); rd(14, "R10");
    // R11 code error exclusive, unmatched ignored
    rx(2000, 1, 1, 1, 0, 0, "R11"); rx(100, 0, 0, 0, 0, 0, "R11");
    rx(30, 0, 0, 0, 0, 0, "R11");
    rd(11, "R11"); rd(13, "R11"); rd(4, "R11"); rd(14, "R11");
    // R12 saturation of an 8-bit counter
    for (int n = 0; n < 260; n++) tx(0, 0, 1, 0, 0, "R12");
    rd(10, "R12"); rd(10, "R12");
    // R13 read and increment in the same cycle
    tx(0, 0, 0, 0, 0, "R13"); tx(0, 0, 0, 0, 0, "R13");
    quiet(); tx_valid = 1; rd_en = 1; rd_addr = 4'd0; step("R13"); quiet();
    rd(0, "R13"); rd(0, "R13");
    // R13 mixed traffic with random reads colliding with increments
    for (int n = 0; n < 4000; n++) begin
      int lens [7] = '{30, 63, 64, 700, 1518, 1519, 2000};
      quiet();
      tx_valid = ($urandom % 2) == 0;
      tx_coll = 5'($urandom % 18);
      tx_late = ($urandom % 4) == 0;
      tx_underrun = ($urandom % 8) == 0;
      tx_carrier_lost = ($urandom % 6) == 0;
      tx_deferred = ($urandom % 3) == 0;
      rx_valid = ($urandom % 2) == 0;
      rx_len = 14'(lens[$urandom % 7]);
      rx_addr_match = ($urandom % 5) != 0;
      rx_code_err = ($urandom % 8) == 0;
      rx_crc_err = ($urandom % 3) == 0;
      rx_dribble = ($urandom % 3) == 0;
      rx_no_buf = ($urandom % 5) == 0;
      rd_en = ($urandom % 4) == 0;
      rd_addr = 4'($urandom % 16);
      step("R13");
    end
    quiet();
    for (int a = 0; a < 16; a++) rd(a, "R13");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule